// File: doc/BRIEF.md
# Two-Tone Beep Generator on a Shared Open-Drain Output

This block drives two open-drain output pins, each described by a pull-low enable. The first pin is either a plain output that follows its output latch bit or carries an audio square-wave tone. The second pin is always a plain output. The tone comes from dividing the 75 kHz system clock. One division gives about 1.5 kHz and the other gives about 3.1 kHz.

A beep command is a 3-bit word. Its top bit selects what the first pin does, and its two low bits select the tone. Output latch writes change both latch bits at once. When the first pin carries the tone, writes to its latch bit are stored but are not seen on the pin. A backup input releases both pins. They stay released after backup ends until the next output write or beep command.

Top module: `beep_port`

## Requirements
- R1: After reset both pins are released (pull enables low), both output latch bits hold 1, and the first pin is in plain-output mode.
- R2: In plain-output mode a latch bit of 0 pulls its pin low and a bit of 1 releases it. Output data bit 0 drives the first pin and bit 1 drives the second pin. The new value appears one cycle after the write edge.
- R3: A beep command with bit 2 = 1 and bits 1:0 = 01 produces a square wave with a period of 50 clocks. The first pin is released for the first 25 cycles after the command edge and pulls low for the next 25 cycles.
- R4: Bits 1:0 = 10 give a period of 24 clocks, as 12 cycles released followed by 12 cycles pulled.
- R5: In tone mode, codes 00 and 11 give no tone, and the first pin stays released.
- R6: In tone mode an output write leaves the first pin's tone unchanged. The written bit is still stored, and it drives the pin once a beep command with bit 2 = 0 returns the pin to plain-output mode.
- R7: The second pin follows its latch bit in every mode of the first pin.
- R8: While backup is high both pins are released at once. After backup falls they stay released until an output write or beep command is accepted.
- R9: Every beep command restarts the tone divider at count zero, with the first pin released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 75 kHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beep_we | input | 1 | Beep command strobe |
| beep_cfg | input | 3 | Bit 2 selects tone mode; bits 1:0 select the tone |
| out_we | input | 1 | Output latch write strobe |
| out_data | input | 2 | Latch values: bit 0 for the first pin, bit 1 for the second |
| backup | input | 1 | Backup-mode indication |
| pin0_pull | output | 1 | Pull-low enable of the shared pin |
| pin1_pull | output | 1 | Pull-low enable of the plain pin |

## Verification
Latch writes and beep commands take effect one cycle after the edge that accepts them, and the backup release takes effect in the same cycle. A tone edge appears a half-period of cycles after the command edge, so 25 or 12 cycles later. The bench drives every input on a falling clock edge and samples on falling edges. It counts rising edges from the command edge and checks the cycle just before each expected tone transition as well as the cycle of the transition. This way, an error of one cycle in either direction is reported.

// File: rtl/beep_port.sv
module beep_port #(
  parameter int DIV_SLOW = 50,
  parameter int DIV_FAST = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beep_we,
  input  logic [2:0] beep_cfg,
  input  logic       out_we,
  input  logic [1:0] out_data,
  input  logic       backup,
  output logic       pin0_pull,
  output logic       pin1_pull
);
  localparam int HALF_S = DIV_SLOW / 2;
  localparam int HALF_F = DIV_FAST / 2;
  localparam int HALF_MAX = (HALF_S > HALF_F) ? HALF_S : HALF_F;
  localparam int CW = $clog2(HALF_MAX + 1);
  localparam logic [CW-1:0] LAST_S = CW'(HALF_S - 1);
  localparam logic [CW-1:0] LAST_F = CW'(HALF_F - 1);

  logic          tone_mode;
  logic [1:0]    sel;
  logic [CW-1:0] cnt;
  logic          phase;
  logic [1:0]    lat;
  logic          hold;
  logic          tone_on;
  logic [CW-1:0] last;
  logic          released;

  assign tone_on  = (sel == 2'b01) || (sel == 2'b10);
  assign last     = (sel == 2'b01) ? LAST_S : LAST_F;
  assign released = backup || hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tone_mode <= 1'b0;
      sel       <= 2'b00;
      cnt       <= '0;
      phase     <= 1'b0;
    end else if (beep_we) begin
      tone_mode <= beep_cfg[2];
      sel       <= beep_cfg[1:0];
      cnt       <= '0;
      phase     <= 1'b0;
    end else if (tone_on) begin
      if (cnt == last) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt   <= '0;
      phase <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat  <= 2'b11;
      hold <= 1'b0;
    end else begin
      if (out_we) lat <= out_data;
      if (backup) hold <= 1'b1;
      else if (out_we || beep_we) hold <= 1'b0;
    end
  end

  assign pin0_pull = !released && (tone_mode ? (tone_on && phase) : !lat[0]);
  assign pin1_pull = !released && !lat[1];

  a_r8_backup_release: assert property (@(posedge clk) disable iff (!rst_n)
    backup |-> (!pin0_pull && !pin1_pull));

  a_r8_hold_after_backup: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(backup) && !backup && !$past(out_we) && !$past(beep_we))
      |-> (!pin0_pull && !pin1_pull));

  a_r5_no_tone_code: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_mode && !tone_on) |-> !pin0_pull);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_S || cnt <= LAST_F);

  a_r4_toggle_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(beep_we) && (phase != $past(phase)))
      |-> ($past(cnt) == $past(last) || !$past(tone_on)));

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    beep_we |=> (cnt == '0 && !phase));

  a_r6_silent_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_mode && $past(tone_mode) && !$past(beep_we) && $stable(phase) && !backup && !hold && $past(!backup && !hold))
      |-> $stable(pin0_pull));
endmodule

// File: tb/test_beep_port.sv
module test_beep_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       beep_we = 1'b0;
  logic [2:0] beep_cfg = 3'b000;
  logic       out_we = 1'b0;
  logic [1:0] out_data = 2'b00;
  logic       backup = 1'b0;
  logic       pin0_pull;
  logic       pin1_pull;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  beep_port i_beep_port (
    .clk(clk), .rst_n(rst_n), .beep_we(beep_we), .beep_cfg(beep_cfg),
    .out_we(out_we), .out_data(out_data), .backup(backup),
    .pin0_pull(pin0_pull), .pin1_pull(pin1_pull)
  );

  // {out_data[1:0], expected {pin1_pull, pin0_pull}}
  localparam logic [3:0] VEC [4] = '{4'b00_11, 4'b01_10, 4'b10_01, 4'b11_00};

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pins(p1,p0)=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr_out(input logic [1:0] d);
    @(negedge clk); out_we = 1'b1; out_data = d;
    @(negedge clk); out_we = 1'b0;
  endtask

  task automatic wr_beep(input logic [2:0] c);
    @(negedge clk); beep_we = 1'b1; beep_cfg = c;
    @(negedge clk); beep_we = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 reset", {pin1_pull, pin0_pull}, 2'b00);

    for (int v = 0; v < 4; v++) begin
      wr_out(VEC[v][3:2]);
      check("R2 latch", {pin1_pull, pin0_pull}, VEC[v][1:0]);
    end

    // R3 slow tone, latch bit1=0 so pin1 pulls (R7)
    wr_out(2'b01);
    wr_beep(3'b101);
    check("R3 start", {pin1_pull, pin0_pull}, 2'b10);
    step(24); check("R3 n24", {pin1_pull, pin0_pull}, 2'b10);
    step(1);  check("R3 n25", {pin1_pull, pin0_pull}, 2'b11);
    step(24); check("R3 n49", {pin1_pull, pin0_pull}, 2'b11);
    step(1);  check("R3 n50", {pin1_pull, pin0_pull}, 2'b10);

    // R4 fast tone, pin1 released (R7)
    wr_out(2'b11);
    wr_beep(3'b110);
    step(11); check("R4 n11", {pin1_pull, pin0_pull}, 2'b00);
    step(1);  check("R4 n12", {pin1_pull, pin0_pull}, 2'b01);
    step(11); check("R4 n23", {pin1_pull, pin0_pull}, 2'b01);
    step(1);  check("R4 n24", {pin1_pull, pin0_pull}, 2'b00);

    // R9 restart mid-period
    step(10);
    wr_beep(3'b110);
    step(11); check("R9 restart n11", {pin1_pull, pin0_pull}, 2'b00);
    step(1);  check("R9 restart n12", {pin1_pull, pin0_pull}, 2'b01);

    // R5 no-tone codes
    wr_beep(3'b100);
    step(30); check("R5 code00", {pin1_pull, pin0_pull}, 2'b00);
    wr_beep(3'b111);
    step(30); check("R5 code11", {pin1_pull, pin0_pull}, 2'b00);

    // R6 latch write silent in tone mode
    wr_beep(3'b101);
    step(2);
    wr_out(2'b10);  // pin0 latch 0 would pull in plain mode
    check("R6 silent", {pin1_pull, pin0_pull}, 2'b00);
    wr_beep(3'b000);
    check("R6 latch kept", {pin1_pull, pin0_pull}, 2'b01);

    // R8 backup
    wr_out(2'b00);
    check("R8 pre", {pin1_pull, pin0_pull}, 2'b11);
    @(negedge clk); backup = 1'b1;
    #1 check("R8 in backup", {pin1_pull, pin0_pull}, 2'b00);
    step(3);
    backup = 1'b0;
    step(5); check("R8 held", {pin1_pull, pin0_pull}, 2'b00);
    wr_out(2'b01);
    check("R8 out write", {pin1_pull, pin0_pull}, 2'b10);
    @(negedge clk); backup = 1'b1;
    step(2); backup = 1'b0;
    step(2); check("R8 held2", {pin1_pull, pin0_pull}, 2'b00);
    wr_out(2'b00);
    wr_beep(3'b000);
    check("R8 beep cmd", {pin1_pull, pin0_pull}, 2'b11);
    @(negedge clk); backup = 1'b1;
    step(2); backup = 1'b0;
    wr_beep(3'b000);
    check("R8 beep only", {pin1_pull, pin0_pull}, 2'b11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule